// File: doc/BRIEF.md
# Serial Potentiometer Command Front End

This block is the slave side of a four-wire serial link (clock, select, data in, data out) with an extra pause input, placed in front of a single digital potentiometer. It runs on the system clock and oversamples the serial pins. A transaction opens when select falls. The first byte is an identification byte that must match a fixed device pattern and the level of a strap input. The second byte carries a 4-bit opcode and a 2-bit register pointer. Depending on the opcode, the block then takes in a data byte, sends out a data byte, commits at once, or enters an open-ended step mode.

Results leave the block as single-cycle command strobes toward a wiper register and a four-entry setting bank. Read data arrives from those neighbours through plain inputs. Write and transfer commands take effect only when select rises after the last byte has fully arrived. Step commands act on each clock pulse as it comes in.

Top module: `potcmd_if`

## Requirements
- R1: The first byte after select falls, received MSB first, must equal 0101 then 110 then the `dev_addr` level. On a mismatch the whole transaction produces no strobe and `spi_so_oe` stays low.
- R2: After reset no command is accepted until `spi_cs_n` has been seen high and then falls. Traffic sent while select is still low from reset has no effect.
- R3: The opcode is bits 7..4 of the second byte. Opcode 1010 followed by a data byte 00ddddd loads the low six bits into the wiper: `wiper_load` pulses with `wdata` set to that value.
- R4: Opcode 1100 writes the data byte's low six bits into the setting register selected by bits 3..2 of the second byte: `reg_write` pulses with `reg_sel` and `wdata` set.
- R5: Opcode 1101 (setting register to wiper) and opcode 1110 (wiper to setting register) end after the second byte. They pulse `reg_to_wiper` or `wiper_to_reg` respectively, with `reg_sel` taken from bits 3..2.
- R6: If select rises before the final byte of a write or transfer is complete, no strobe is issued.
- R7: Opcodes 1001 (wiper), 1011 (setting register at the pointer) and 0101 (status) return a third byte MSB first. The byte is 00 followed by the six value bits, or seven zeros followed by `nv_busy` for status. Each bit changes after a falling clock edge, so it is valid at the next rising edge.
- R8: After opcode 0010, every rising clock edge until select rises gives one `step_pulse`. `step_up` is high on that pulse when data in was high at the edge and low otherwise.
- R9: `spi_so_oe` is low while select is high, outside the data byte of a read, and for the whole of a transaction with an unknown opcode. An unknown opcode issues no strobe.
- R10: Pause low, sampled while the serial clock is low, freezes the transaction and drops `spi_so_oe`. Clock edges during the pause are ignored. Pause high, again sampled with the clock low, resumes from the same bit.
- R11: Strobes last one system clock and at most one is active at a time. A write or transfer strobe is high in the cycle right after the first system clock edge that sees select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| dev_addr | input | 1 | Strap level compared with the ID byte LSB |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for serial data out |
| wiper_cur | input | 6 | Current wiper value for reads |
| reg_rdata | input | 6 | Setting register at `reg_sel` |
| nv_busy | input | 1 | Storage write in progress, returned by status |
| reg_sel | output | 2 | Register pointer of the last command |
| wdata | output | 6 | Write data for wiper or setting register |
| wiper_load | output | 1 | Load wiper from `wdata` |
| reg_write | output | 1 | Write setting register `reg_sel` |
| reg_to_wiper | output | 1 | Copy setting register `reg_sel` into wiper |
| wiper_to_reg | output | 1 | Copy wiper into setting register `reg_sel` |
| step_pulse | output | 1 | One wiper step |
| step_up | output | 1 | Direction of the step, high for up |

## Verification
The assertions assume that the serial pins are already synchronous to `clk`. They also assume that each level of the serial clock lasts at least two system clocks, so that every edge is seen exactly once. Pause is assumed to change only while the serial clock is low. The stimulus drives every pin on the falling system clock edge and holds each serial clock level for several cycles. It moves pause only in the clock-low phase, including the case where clock pulses are sent while paused.

// File: rtl/pcif_pkg.sv
package pcif_pkg;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 4;

  localparam logic [3:0] ID_TYPE = 4'b0101;
  localparam logic [2:0] ID_FIX  = 3'b110;

  localparam logic [OPC_W-1:0] OPC_RD_WIPER = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_WR_WIPER = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_RD_REG   = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_WR_REG   = 4'b1100;
  localparam logic [OPC_W-1:0] OPC_REG2WIP  = 4'b1101;
  localparam logic [OPC_W-1:0] OPC_WIP2REG  = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_STEP     = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_RD_STAT  = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_ARMED, ST_DROP
  } fsm_t;

  typedef enum logic [2:0] {
    CM_NONE, CM_WIPER, CM_REG, CM_R2W, CM_W2R
  } commit_t;

  typedef enum logic [1:0] {
    RS_WIPER, RS_REG, RS_STAT
  } rdsrc_t;
endpackage

// File: rtl/pcif_edges.sv
module pcif_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sel,
  output logic paused,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic sck_q, cs_q, sel_q, paused_q;
  logic sel_d, paused_d;
  logic live;

  // cs_q resets low: a select that is already low at reset never counts as a fall
  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = sel_q & cs_n;
  assign live     = sel_q & ~cs_n & ~paused_q;
  assign sck_rise = live & sck & ~sck_q;
  assign sck_fall = live & ~sck & sck_q;
  assign sel      = sel_q;
  assign paused   = paused_q;

  always_comb begin
    sel_d    = sel_q;
    paused_d = paused_q;
    if (cs_fall) begin
      sel_d = 1'b1;
    end else if (cs_n) begin
      sel_d = 1'b0;
    end
    if (!sel_q || cs_n) begin
      paused_d = 1'b0;
    end else if (!sck) begin
      paused_d = ~hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b0;
      sel_q    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_q    <= sck;
      cs_q     <= cs_n;
      sel_q    <= sel_d;
      paused_q <= paused_d;
    end
  end

  AST_SEL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(cs_q)); // R2

  AST_PAUSE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_q) |-> !$past(sck)); // R10
endmodule

// File: rtl/pcif_decoder.sv
module pcif_decoder
  import pcif_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              si,
  input  logic              dev_addr,
  output logic              out_phase,
  output rdsrc_t            rd_src,
  output logic [PTR_W-1:0]  reg_sel,
  output logic [DATA_W-1:0] wdata,
  output logic              wiper_load,
  output logic              reg_write,
  output logic              reg_to_wiper,
  output logic              wiper_to_reg,
  output logic              step_pulse,
  output logic              step_up
);
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam int PTR_LSB = BYTE_W - OPC_W - PTR_W;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  fsm_t                state_q, state_d;
  commit_t             pend_q, pend_d;
  rdsrc_t              src_q, src_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic [DATA_W-1:0]   wd_q, wd_d;
  logic                wl_q, wl_d, rw_q, rw_d, r2w_q, r2w_d, w2r_q, w2r_d;
  logic                stp_q, stp_d, up_q, up_d;
  logic [BYTE_W-1:0]   byte_now;
  logic [OPC_W-1:0]    opc;
  logic                last;

  assign byte_now = {sh_q, si};
  assign opc      = byte_now[BYTE_W-1 -: OPC_W];
  assign last     = (idx_q == IDX_LAST);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    src_d   = src_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    wd_d    = wd_q;
    up_d    = up_q;
    wl_d    = 1'b0;
    rw_d    = 1'b0;
    r2w_d   = 1'b0;
    w2r_d   = 1'b0;
    stp_d   = 1'b0;
    if (cs_fall) begin
      state_d = ST_ID;
      pend_d  = CM_NONE;
      idx_d   = '0;
    end else if (cs_rise) begin
      if (state_q == ST_ARMED) begin
        case (pend_q)
          CM_WIPER: wl_d  = 1'b1;
          CM_REG:   rw_d  = 1'b1;
          CM_R2W:   r2w_d = 1'b1;
          CM_W2R:   w2r_d = 1'b1;
          default:  ;
        endcase
      end
      state_d = ST_IDLE;
    end else if (sck_rise) begin
      idx_d = idx_q + 1'b1;
      sh_d  = byte_now[BYTE_W-2:0];
      case (state_q)
        ST_ID: begin
          if (last) begin
            if (byte_now == {ID_TYPE, ID_FIX, dev_addr}) state_d = ST_INSTR;
            else                                         state_d = ST_DROP;
          end
        end
        ST_INSTR: begin
          if (last) begin
            ptr_d = byte_now[PTR_LSB +: PTR_W];
            case (opc)
              OPC_RD_WIPER: begin state_d = ST_RDATA; src_d = RS_WIPER; end
              OPC_RD_REG:   begin state_d = ST_RDATA; src_d = RS_REG;   end
              OPC_RD_STAT:  begin state_d = ST_RDATA; src_d = RS_STAT;  end
              OPC_WR_WIPER: begin state_d = ST_WDATA; pend_d = CM_WIPER; end
              OPC_WR_REG:   begin state_d = ST_WDATA; pend_d = CM_REG;   end
              OPC_REG2WIP:  begin state_d = ST_ARMED; pend_d = CM_R2W;   end
              OPC_WIP2REG:  begin state_d = ST_ARMED; pend_d = CM_W2R;   end
              OPC_STEP:     state_d = ST_STEP;
              default:      state_d = ST_DROP;
            endcase
          end
        end
        ST_WDATA: begin
          if (last) begin
            wd_d    = byte_now[DATA_W-1:0];
            state_d = ST_ARMED;
          end
        end
        ST_STEP: begin
          stp_d = 1'b1;
          up_d  = si;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= CM_NONE;
      src_q   <= RS_WIPER;
      idx_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      wd_q    <= '0;
      wl_q    <= 1'b0;
      rw_q    <= 1'b0;
      r2w_q   <= 1'b0;
      w2r_q   <= 1'b0;
      stp_q   <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      src_q   <= src_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      wd_q    <= wd_d;
      wl_q    <= wl_d;
      rw_q    <= rw_d;
      r2w_q   <= r2w_d;
      w2r_q   <= w2r_d;
      stp_q   <= stp_d;
      up_q    <= up_d;
    end
  end

  assign out_phase    = (state_q == ST_RDATA);
  assign rd_src       = src_q;
  assign reg_sel      = ptr_q;
  assign wdata        = wd_q;
  assign wiper_load   = wl_q;
  assign reg_write    = rw_q;
  assign reg_to_wiper = r2w_q;
  assign wiper_to_reg = w2r_q;
  assign step_pulse   = stp_q;
  assign step_up      = up_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wl_q, rw_q, r2w_q, w2r_q, stp_q})); // R11

  AST_COMMIT_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_q | rw_q | r2w_q | w2r_q) |-> $past(cs_rise)); // R11

  AST_STEP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    stp_q |-> $past(sck_rise)); // R8

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |=> !(wl_q | rw_q | r2w_q | w2r_q | stp_q)); // R1
endmodule

// File: rtl/pcif_txshift.sv
module pcif_txshift
  import pcif_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              out_phase,
  input  rdsrc_t            rd_src,
  input  logic [DATA_W-1:0] wiper_val,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              busy,
  output logic              so_bit
);
  logic [BYTE_W-1:0] val;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              first_q, first_d;
  logic              so_q, so_d;

  always_comb begin
    case (rd_src)
      RS_WIPER: val = BYTE_W'(wiper_val);
      RS_REG:   val = BYTE_W'(reg_val);
      default:  val = BYTE_W'(busy);
    endcase
  end

  always_comb begin
    tx_d    = tx_q;
    first_d = first_q;
    so_d    = so_q;
    if (!out_phase) begin
      first_d = 1'b1;
    end else if (sck_fall) begin
      first_d = 1'b0;
      if (first_q) begin
        so_d = val[BYTE_W-1];
        tx_d = {val[BYTE_W-2:0], 1'b0};
      end else begin
        so_d = tx_q[BYTE_W-1];
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      first_q <= 1'b1;
      so_q    <= 1'b0;
    end else begin
      tx_q    <= tx_d;
      first_q <= first_d;
      so_q    <= so_d;
    end
  end

  assign so_bit = so_q;

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(so_q)); // R7
endmodule

// File: rtl/potcmd_if.sv
module potcmd_if
  import pcif_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int NREG   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_si,
  input  logic                     spi_hold_n,
  input  logic                     dev_addr,
  output logic                     spi_so,
  output logic                     spi_so_oe,
  input  logic [DATA_W-1:0]        wiper_cur,
  input  logic [DATA_W-1:0]        reg_rdata,
  input  logic                     nv_busy,
  output logic [$clog2(NREG)-1:0]  reg_sel,
  output logic [DATA_W-1:0]        wdata,
  output logic                     wiper_load,
  output logic                     reg_write,
  output logic                     reg_to_wiper,
  output logic                     wiper_to_reg,
  output logic                     step_pulse,
  output logic                     step_up
);
  localparam int PTR_W = $clog2(NREG);

  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       sel, paused, sck_rise, sck_fall, cs_fall, cs_rise;
  logic       out_phase;
  rdsrc_t     rd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  pcif_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_s),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .hold_n   (spi_hold_n),
    .sel      (sel),
    .paused   (paused),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise)
  );

  pcif_decoder #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_s),
    .sck_rise     (sck_rise),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .si           (spi_si),
    .dev_addr     (dev_addr),
    .out_phase    (out_phase),
    .rd_src       (rd_src),
    .reg_sel      (reg_sel),
    .wdata        (wdata),
    .wiper_load   (wiper_load),
    .reg_write    (reg_write),
    .reg_to_wiper (reg_to_wiper),
    .wiper_to_reg (wiper_to_reg),
    .step_pulse   (step_pulse),
    .step_up      (step_up)
  );

  pcif_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_s),
    .sck_fall  (sck_fall),
    .out_phase (out_phase),
    .rd_src    (rd_src),
    .wiper_val (wiper_cur),
    .reg_val   (reg_rdata),
    .busy      (nv_busy),
    .so_bit    (spi_so)
  );

  assign spi_so_oe = sel & ~paused & out_phase & ~spi_cs_n;

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_s)
    (paused && $past(paused)) |-> $stable(u_dec.idx_q)); // R10
endmodule

// File: tb/test_potcmd_if.sv
module test_potcmd_if;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, sck, cs_n, si, hold_n, dev_addr, nv_busy;
  logic       so, so_oe;
  logic [5:0] wiper_cur, reg_rdata, wdata;
  logic [1:0] reg_sel;
  logic       wiper_load, reg_write, reg_to_wiper, wiper_to_reg, step_pulse, step_up;

  int n_chk = 0, n_fail = 0;
  int c_wl = 0, c_rw = 0, c_r2w = 0, c_w2r = 0, c_up = 0, c_dn = 0, spur = 0;
  logic [5:0] m_wiper;
  logic [5:0] m_regs [4];
  logic cs_prev = 1'b0;
  bit   done = 1'b0;

  localparam logic [7:0] ID_OK = 8'h5D;

  assign wiper_cur = m_wiper;
  assign reg_rdata = m_regs[reg_sel];

  potcmd_if i_potcmd_if (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .dev_addr(dev_addr), .spi_so(so), .spi_so_oe(so_oe),
    .wiper_cur(wiper_cur), .reg_rdata(reg_rdata), .nv_busy(nv_busy),
    .reg_sel(reg_sel), .wdata(wdata), .wiper_load(wiper_load),
    .reg_write(reg_write), .reg_to_wiper(reg_to_wiper),
    .wiper_to_reg(wiper_to_reg), .step_pulse(step_pulse), .step_up(step_up)
  );

  // behavioural potentiometer model, updated from the strobes every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      m_wiper = '0;
      for (int i = 0; i < 4; i++) m_regs[i] = '0;
    end else begin
      if (wiper_load)   begin m_wiper = wdata; c_wl++; end
      if (reg_write)    begin m_regs[reg_sel] = wdata; c_rw++; end
      if (reg_to_wiper) begin m_wiper = m_regs[reg_sel]; c_r2w++; end
      if (wiper_to_reg) begin m_regs[reg_sel] = m_wiper; c_w2r++; end
      if (step_pulse) begin
        if (step_up) begin c_up++; if (m_wiper != 6'd63) m_wiper = m_wiper + 1'b1; end
        else         begin c_dn++; if (m_wiper != 6'd0)  m_wiper = m_wiper - 1'b1; end
      end
      if (cs_n && cs_prev && so_oe) spur++;
      cs_prev = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic v, output logic r, output logic oe);
    si = v; tk(2);
    r = so; oe = so_oe;
    sck = 1'b1; tk(3);
    sck = 1'b0; tk(2);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] r, output logic oe_any);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic rb, ob;
      sbit(b[i], rb, ob);
      r[i] = rb;
      oe_any = oe_any | ob;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tk(2);
  endtask

  task automatic cs_hi(output logic [4:0] s1, output logic [4:0] s2);
    cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    s1 = {wiper_load, reg_write, reg_to_wiper, wiper_to_reg, step_pulse};
    tk(1);
    s2 = {wiper_load, reg_write, reg_to_wiper, wiper_to_reg, step_pulse};
    tk(3);
  endtask

  task automatic xfer(input logic [7:0] id, input logic [7:0] ins, input bit three,
                      input logic [7:0] dat, output logic [7:0] rd, output logic oe,
                      output logic [4:0] s1, output logic [4:0] s2);
    logic [7:0] dump; logic o;
    rd = '0; oe = 1'b0;
    cs_lo();
    sbyte(id, dump, o);
    sbyte(ins, dump, o);
    if (three) sbyte(dat, rd, oe);
    cs_hi(s1, s2);
  endtask

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] p);
    return {op, p, 2'b00};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] rd, dump; logic oe, o, rb; logic [4:0] s1, s2;
    int up0, dn0, w0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hold_n = 1'b1;
    dev_addr = 1'b1; nv_busy = 1'b0;
    tk(4); rst_n = 1'b1; tk(4);

    chk(so_oe == 1'b0, "R9 reset so_oe", so_oe, 0);
    chk({wiper_load, reg_write, reg_to_wiper, wiper_to_reg, step_pulse} == 5'b0,
        "R11 reset strobes", {wiper_load, reg_write, reg_to_wiper, wiper_to_reg, step_pulse}, 0);

    // R2: select low since reset, no fall seen
    sbyte(ID_OK, dump, o); sbyte(ins(4'b1010, 2'b00), dump, o); sbyte(8'h2A, dump, o);
    cs_hi(s1, s2);
    chk(s1 == 5'b0 && c_wl == 0, "R2 no command before select fall", c_wl, 0);

    // R3 / R11 write wiper
    xfer(ID_OK, ins(4'b1010, 2'b00), 1'b1, 8'h2A, rd, oe, s1, s2);
    chk(s1 == 5'b10000, "R11 wiper_load timing", s1, 5'b10000);
    chk(s2 == 5'b00000, "R11 single-cycle strobe", s2, 0);
    chk(m_wiper == 6'h2A, "R3 wiper value", m_wiper, 6'h2A);

    // R7 read wiper
    xfer(ID_OK, ins(4'b1001, 2'b00), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(rd == 8'h2A && oe, "R7 read wiper", rd, 8'h2A);

    // R4 write register 2, read back
    xfer(ID_OK, ins(4'b1100, 2'b10), 1'b1, 8'h15, rd, oe, s1, s2);
    chk(s1 == 5'b01000 && m_regs[2] == 6'h15, "R4 register write", m_regs[2], 6'h15);
    xfer(ID_OK, ins(4'b1011, 2'b10), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(rd == 8'h15, "R7 read register 2", rd, 8'h15);
    xfer(ID_OK, ins(4'b1011, 2'b00), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(rd == 8'h00, "R7 read register 0", rd, 0);

    // R5 transfers
    xfer(ID_OK, ins(4'b1101, 2'b10), 1'b0, 8'h00, rd, oe, s1, s2);
    chk(s1 == 5'b00100 && m_wiper == 6'h15, "R5 register to wiper", m_wiper, 6'h15);
    xfer(ID_OK, ins(4'b1010, 2'b00), 1'b1, 8'h33, rd, oe, s1, s2);
    xfer(ID_OK, ins(4'b1110, 2'b01), 1'b0, 8'h00, rd, oe, s1, s2);
    chk(s1 == 5'b00010 && m_regs[1] == 6'h33, "R5 wiper to register", m_regs[1], 6'h33);

    // R6 aborts
    cs_lo(); sbyte(ID_OK, dump, o); sbyte(ins(4'b1010, 2'b00), dump, o);
    for (int i = 0; i < 5; i++) sbit(1'b1, rb, o);
    cs_hi(s1, s2);
    chk(s1 == 5'b0 && m_wiper == 6'h33, "R6 short write", m_wiper, 6'h33);
    cs_lo(); sbyte(ID_OK, dump, o);
    for (int i = 0; i < 4; i++) sbit(1'b1, rb, o);
    cs_hi(s1, s2);
    chk(s1 == 5'b0, "R6 short transfer", s1, 0);

    // R1 identification mismatch
    xfer(8'h5C, ins(4'b1010, 2'b00), 1'b1, 8'h01, rd, oe, s1, s2);
    chk(s1 == 5'b0 && m_wiper == 6'h33, "R1 address bit mismatch", m_wiper, 6'h33);
    xfer(8'h5F, ins(4'b1010, 2'b00), 1'b1, 8'h01, rd, oe, s1, s2);
    chk(s1 == 5'b0 && m_wiper == 6'h33, "R1 fixed field mismatch", m_wiper, 6'h33);
    xfer(8'h5C, ins(4'b1001, 2'b00), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(oe == 1'b0, "R1 no drive on mismatch", oe, 0);

    // R7 status
    nv_busy = 1'b1;
    xfer(ID_OK, ins(4'b0101, 2'b00), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(rd == 8'h01, "R7 status busy", rd, 1);
    nv_busy = 1'b0;
    xfer(ID_OK, ins(4'b0101, 2'b00), 1'b1, 8'h00, rd, oe, s1, s2);
    chk(rd == 8'h00, "R7 status idle", rd, 0);

    // R9 unknown opcode
    w0 = c_wl + c_rw + c_r2w + c_w2r + c_up + c_dn;
    xfer(ID_OK, ins(4'b0000, 2'b00), 1'b1, 8'hFF, rd, oe, s1, s2);
    chk(oe == 1'b0 && (c_wl + c_rw + c_r2w + c_w2r + c_up + c_dn) == w0,
        "R9 unknown opcode silent", oe, 0);

    // R8 steps
    xfer(ID_OK, ins(4'b1010, 2'b00), 1'b1, 8'h3D, rd, oe, s1, s2);
    up0 = c_up; dn0 = c_dn;
    cs_lo(); sbyte(ID_OK, dump, o); sbyte(ins(4'b0010, 2'b00), dump, o);
    chk(c_up == up0 && c_dn == dn0, "R8 no step before mode", c_up - up0, 0);
    sbit(1'b1, rb, o); sbit(1'b1, rb, o); sbit(1'b1, rb, o);
    sbit(1'b0, rb, o); sbit(1'b0, rb, o);
    cs_hi(s1, s2);
    chk(c_up - up0 == 3, "R8 up steps", c_up - up0, 3);
    chk(c_dn - dn0 == 2, "R8 down steps", c_dn - dn0, 2);
    chk(m_wiper == 6'd61 && s1 == 5'b0, "R8 final wiper", m_wiper, 61);

    // R10 pause during write
    cs_lo(); sbyte(ID_OK, dump, o); sbyte(ins(4'b1010, 2'b00), dump, o);
    sbit(1'b0, rb, o); sbit(1'b0, rb, o); sbit(1'b1, rb, o);
    hold_n = 1'b0; tk(2);
    for (int i = 0; i < 3; i++) begin si = 1'b1; sck = 1'b1; tk(3); sck = 1'b0; tk(3); end
    hold_n = 1'b1; tk(2);
    sbit(1'b0, rb, o); sbit(1'b1, rb, o); sbit(1'b1, rb, o); sbit(1'b0, rb, o); sbit(1'b0, rb, o);
    cs_hi(s1, s2);
    chk(m_wiper == 6'h2C, "R10 pause in write", m_wiper, 6'h2C);

    // R10 pause during read
    cs_lo(); sbyte(ID_OK, dump, o); sbyte(ins(4'b1001, 2'b00), dump, o);
    rd = '0;
    for (int i = 7; i >= 5; i--) begin sbit(1'b0, rb, o); rd[i] = rb; end
    hold_n = 1'b0; tk(2);
    chk(so_oe == 1'b0, "R10 drive off while paused", so_oe, 0);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; tk(3); sck = 1'b0; tk(3); end
    hold_n = 1'b1; tk(2);
    chk(so_oe == 1'b1, "R10 drive back after resume", so_oe, 1);
    for (int i = 4; i >= 0; i--) begin sbit(1'b0, rb, o); rd[i] = rb; end
    cs_hi(s1, s2);
    chk(rd == 8'h2C, "R10 read resumes at same bit", rd, 8'h2C);

    chk(spur == 0, "R9 no drive while deselected", spur, 0);
    finish_run();
  end
endmodule